// File: doc/BRIEF.md
# FIFO Depth-Expansion Chain Controller

This block is the control slice that lets several identical FIFO storage slices work together as one deeper FIFO. Each slice keeps its own write pointer, read pointer and occupancy count, and drives the write and read side of a storage array that sits outside the block. Write ownership and read ownership are two separate tokens that travel around a ring of slices. A slice may accept data only while it holds the write token, and may hand out data only while it holds the read token. When a slice stores into its last physical location, or hands out data from that location, it sends the matching token to the next slice in the ring over a one-cycle handoff pulse.

Two strap pins are sampled during reset. The `standalone` strap makes the slice a self-contained FIFO. In that case it holds both tokens permanently, sends no handoff pulses and ignores incoming ones. The pin `load_rt` has two meanings. In chain mode its level during reset marks the head slice, which starts with both tokens. In standalone mode, a high level after reset is a retransmit request that rewinds the read side to location 0.

Writes use a valid/ready handshake: a word transfers in a cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` is low when the slice lacks the write token, when it is full, or during a retransmit cycle. A producer holds its word and `wr_valid` until it sees `wr_ready`. Reads use the same rule with `rd_valid` from the block and `rd_ready` from the consumer. The consumer takes the word from the storage array at `mem_raddr` in the transfer cycle. At chain level, the ready, valid and flag outputs of all slices are ORed together, and the read data is taken from the slice that shows `rd_valid`.

Top module: `fifo_chain_slice_ctrl`

## Requirements
- R1: During reset, a slice with `standalone`=1, or with `standalone`=0 and `load_rt`=1, takes both tokens. After reset it shows `wr_ready`=1, `empty_flag`=1 and `full_flag`=0. A chain slice with `load_rt`=0 during reset shows `wr_ready`=0, `rd_valid`=0 and both flags 0.
- R2: A write transfers only when `wr_valid` and `wr_ready` are both high. `wr_ready` is 1 exactly when the slice holds the write token, holds fewer than DEPTH words and no retransmit is requested. A transfer raises `mem_we` in the same cycle at `mem_waddr`, and the write address then advances by one, wrapping from DEPTH-1 to 0. A slice without the write token never raises `mem_we`.
- R3: `rd_valid` is 1 exactly when the slice holds the read token, holds at least one word and no retransmit is requested. A read transfer raises `mem_re` at `mem_raddr`, and the read address advances the same way as the write address. A slice that holds data but not the read token keeps `rd_valid` low.
- R4: In chain mode, a write into location DEPTH-1 releases the write token at that clock edge. In the following cycle only, `xout_pulse`=1 and `xout_rd`=0. A read from location DEPTH-1 does the same with `xout_rd`=1.
- R5: In chain mode, a cycle with `xin_pulse`=1 gives the slice the write token at the next edge when `xin_rd`=0, and the read token when `xin_rd`=1.
- R6: In standalone mode, both tokens are kept for good, `xout_pulse` stays 0, `xin_pulse` has no effect, and both addresses wrap within the slice.
- R7: In standalone mode, a cycle with `load_rt`=1 blocks both transfers (`wr_ready`=0, `rd_valid`=0). At the next edge the read address becomes 0 and the occupancy becomes the current write address. The words written since reset are then replayed in order, as long as fewer than DEPTH were written.
- R8: In chain mode, `load_rt` has no effect after reset.
- R9: `full_flag` = write token held and DEPTH words stored. `empty_flag` = read token held and no word stored. The OR of all slices' flags gives the chain status.
- R10: A ring of N slices with one head behaves as a single FIFO of N×DEPTH words that keeps the order of the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the straps are sampled while it is low |
| standalone | input | 1 | Strap: 1 selects standalone mode, 0 selects chain mode |
| load_rt | input | 1 | Head marker during reset in chain mode; retransmit request in standalone mode |
| xin_pulse | input | 1 | Token handoff from the previous slice |
| xin_rd | input | 1 | Tag of the incoming handoff: 0 write token, 1 read token |
| xout_pulse | output | 1 | Token handoff to the next slice, one cycle wide |
| xout_rd | output | 1 | Tag of the outgoing handoff: 0 write token, 1 read token |
| wr_valid | input | 1 | Producer offers a word |
| wr_ready | output | 1 | Slice accepts a word this cycle |
| rd_valid | output | 1 | Slice offers a word this cycle |
| rd_ready | input | 1 | Consumer takes the offered word |
| mem_we | output | 1 | Storage write strobe |
| mem_waddr | output | $clog2(DEPTH) | Storage write address |
| mem_re | output | 1 | Storage read strobe |
| mem_raddr | output | $clog2(DEPTH) | Storage read address |
| full_flag | output | 1 | Full, reported by the write-token holder |
| empty_flag | output | 1 | Empty, reported by the read-token holder |

## Verification
The bench builds a two-slice ring with small storage models. It fills the ring and checks that the first slice gives up write ownership right after its last location. A design that wraps the pointer without passing the token would overwrite unread words, and the scoreboard would see data out of order. The bench also parks data in the second slice while the first still owns reading. A slice that ignored read-token gating would then deliver words early. It pulses the dual-purpose pin in chain mode, which a design that retransmits regardless of mode would answer by discarding stored words. In standalone mode it checks retransmit blocking and rewind, confirms that incoming pulses are ignored, and checks that wrapping produces no outgoing pulse.

// File: rtl/fifo_chain_pkg.sv
`timescale 1ns/1ps
package fifo_chain_pkg;

  // Tag carried on a handoff pulse.
  typedef enum logic {
    HAND_WR = 1'b0,
    HAND_RD = 1'b1
  } hand_kind_e;

  // Role of a slice, latched from the straps during reset.
  typedef enum logic [1:0] {
    MODE_SOLO       = 2'd0,
    MODE_CHAIN_HEAD = 2'd1,
    MODE_CHAIN_BODY = 2'd2
  } slice_mode_e;

  typedef enum logic {
    TOK_AWAY = 1'b0,
    TOK_HELD = 1'b1
  } tok_state_e;

endpackage

// File: rtl/fcc_mode_decode.sv
`timescale 1ns/1ps
module fcc_mode_decode
  import fifo_chain_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        standalone,
  input  logic        load_rt,
  output slice_mode_e mode,
  output logic        chain_en,
  output logic        rt_req
);

  slice_mode_e mode_q;

  // Straps are captured while reset is held and frozen afterwards.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if (standalone)   mode_q <= MODE_SOLO;
      else if (load_rt) mode_q <= MODE_CHAIN_HEAD;
      else              mode_q <= MODE_CHAIN_BODY;
    end
  end

  assign mode     = mode_q;
  assign chain_en = (mode_q != MODE_SOLO);
  // The shared pin means retransmit only for a standalone slice.
  assign rt_req   = (mode_q == MODE_SOLO) && load_rt;

endmodule

// File: rtl/fcc_token.sv
`timescale 1ns/1ps
module fcc_token
  import fifo_chain_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic own_at_reset,
  input  logic take,
  input  logic give,
  output logic held
);

  tok_state_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= own_at_reset ? TOK_HELD : TOK_AWAY;
    end else begin
      unique case (state)
        TOK_HELD: if (give) state <= TOK_AWAY;
        TOK_AWAY: if (take) state <= TOK_HELD;
        default:  state <= TOK_AWAY;
      endcase
    end
  end

  assign held = (state == TOK_HELD);

endmodule

// File: rtl/fcc_ptr.sv
`timescale 1ns/1ps
module fcc_ptr #(
  parameter int DEPTH = 512
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     step,
  input  logic                     clear,
  output logic [$clog2(DEPTH)-1:0] ptr,
  output logic                     at_last
);

  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr <= '0;
    else if (clear)   ptr <= '0;
    else if (step)    ptr <= at_last ? '0 : ptr + 1'b1;
  end

  assign at_last = (ptr == LAST);

endmodule

// File: rtl/fcc_handoff.sv
`timescale 1ns/1ps
module fcc_handoff
  import fifo_chain_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_wrap,
  input  logic       rd_wrap,
  output logic       pulse,
  output hand_kind_e kind
);

  // Both wraps in one slice in one cycle cannot occur: equal pointers
  // mean the slice is either empty or full, which blocks one side.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse <= 1'b0;
      kind  <= HAND_WR;
    end else begin
      pulse <= wr_wrap | rd_wrap;
      kind  <= rd_wrap ? HAND_RD : HAND_WR;
    end
  end

endmodule

// File: rtl/fifo_chain_slice_ctrl.sv
`timescale 1ns/1ps
module fifo_chain_slice_ctrl
  import fifo_chain_pkg::*;
#(
  parameter int DEPTH = 512
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     standalone,
  input  logic                     load_rt,
  input  logic                     xin_pulse,
  input  logic                     xin_rd,
  output logic                     xout_pulse,
  output logic                     xout_rd,
  input  logic                     wr_valid,
  output logic                     wr_ready,
  output logic                     rd_valid,
  input  logic                     rd_ready,
  output logic                     mem_we,
  output logic [$clog2(DEPTH)-1:0] mem_waddr,
  output logic                     mem_re,
  output logic [$clog2(DEPTH)-1:0] mem_raddr,
  output logic                     full_flag,
  output logic                     empty_flag
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  slice_mode_e mode;
  logic        chain_en;
  logic        rt_req;

  fcc_mode_decode u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .standalone(standalone),
    .load_rt   (load_rt),
    .mode      (mode),
    .chain_en  (chain_en),
    .rt_req    (rt_req)
  );

  logic          own_w, own_r;
  logic          wr_fire, rd_fire;
  logic          w_last, r_last;
  logic          wr_wrap, rd_wrap;
  logic          take_w, take_r;
  logic          reset_own;
  logic [CW-1:0] count;
  hand_kind_e    in_kind, out_kind;

  assign in_kind   = xin_rd ? HAND_RD : HAND_WR;
  assign reset_own = standalone | load_rt;
  assign take_w    = chain_en & xin_pulse & (in_kind == HAND_WR);
  assign take_r    = chain_en & xin_pulse & (in_kind == HAND_RD);

  fcc_token u_wtok (
    .clk         (clk),
    .rst_n       (rst_n),
    .own_at_reset(reset_own),
    .take        (take_w),
    .give        (wr_wrap),
    .held        (own_w)
  );

  fcc_token u_rtok (
    .clk         (clk),
    .rst_n       (rst_n),
    .own_at_reset(reset_own),
    .take        (take_r),
    .give        (rd_wrap),
    .held        (own_r)
  );

  // Strobe gating
  assign wr_ready = own_w & (count != CAP) & ~rt_req;
  assign rd_valid = own_r & (count != '0) & ~rt_req;
  assign wr_fire  = wr_valid & wr_ready;
  assign rd_fire  = rd_valid & rd_ready;
  assign wr_wrap  = chain_en & wr_fire & w_last;
  assign rd_wrap  = chain_en & rd_fire & r_last;

  fcc_ptr #(.DEPTH(DEPTH)) u_wptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (wr_fire),
    .clear  (1'b0),
    .ptr    (mem_waddr),
    .at_last(w_last)
  );

  fcc_ptr #(.DEPTH(DEPTH)) u_rptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (rd_fire),
    .clear  (rt_req),
    .ptr    (mem_raddr),
    .at_last(r_last)
  );

  // Local occupancy
  always_ff @(posedge clk) begin
    if (!rst_n)                  count <= '0;
    else if (rt_req)             count <= CW'(mem_waddr);
    else if (wr_fire && !rd_fire) count <= count + 1'b1;
    else if (rd_fire && !wr_fire) count <= count - 1'b1;
  end

  fcc_handoff u_ho (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_wrap(wr_wrap),
    .rd_wrap(rd_wrap),
    .pulse  (xout_pulse),
    .kind   (out_kind)
  );

  assign xout_rd    = (out_kind == HAND_RD);
  assign mem_we     = wr_fire;
  assign mem_re     = rd_fire;
  assign full_flag  = own_w & (count == CAP);
  assign empty_flag = own_r & (count == '0);

endmodule

// File: rtl/fcc_checker.sv
`timescale 1ns/1ps
module fcc_checker #(
  parameter int DEPTH = 512
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     standalone,
  input logic                     load_rt,
  input logic                     xout_pulse,
  input logic                     xout_rd,
  input logic                     wr_ready,
  input logic                     rd_valid,
  input logic                     mem_we,
  input logic [$clog2(DEPTH)-1:0] mem_waddr,
  input logic                     mem_re,
  input logic [$clog2(DEPTH)-1:0] mem_raddr
);

  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  a_r2_waddr_steps: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (mem_waddr == (($past(mem_waddr) == LAST) ? '0 : $past(mem_waddr) + 1'b1)));

  a_r3_raddr_steps: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> (mem_raddr == (($past(mem_raddr) == LAST) ? '0 : $past(mem_raddr) + 1'b1)));

  a_r4_wr_handoff: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_waddr == LAST && !standalone) |=> (xout_pulse && !xout_rd && !wr_ready));

  a_r4_rd_handoff: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && mem_raddr == LAST && !standalone) |=> (xout_pulse && xout_rd && !rd_valid));

  a_r4_no_dual_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re && mem_waddr == LAST && mem_raddr == LAST));

  a_r6_solo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    standalone |-> !xout_pulse);

  a_r7_rt_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (standalone && load_rt) |-> (!mem_we && !mem_re));

  a_r7_rt_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    (standalone && load_rt) |=> (mem_raddr == '0));

endmodule

bind fifo_chain_slice_ctrl fcc_checker #(.DEPTH(DEPTH)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .standalone(standalone),
  .load_rt   (load_rt),
  .xout_pulse(xout_pulse),
  .xout_rd   (xout_rd),
  .wr_ready  (wr_ready),
  .rd_valid  (rd_valid),
  .mem_we    (mem_we),
  .mem_waddr (mem_waddr),
  .mem_re    (mem_re),
  .mem_raddr (mem_raddr)
);

// File: tb/fifo_chain_slice_ctrl_tb_top.sv
`timescale 1ns/1ps
module fifo_chain_slice_ctrl_tb_top;

  localparam int D  = 4;
  localparam int AW = $clog2(D);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  int n_chk = 0, n_fail = 0;

  // chain-level stimulus
  logic       c_wv, c_rr, rt1;
  logic [7:0] c_wd;
  // standalone stimulus
  logic       wv2, rr2, rt2, x2ip, x2ir;
  logic [7:0] wd2;

  logic w0r, v0, we0, re0, x0p, x0r, f0, e0;
  logic w1r, v1, we1, re1, x1p, x1r, f1, e1;
  logic w2r, v2, we2, re2, x2p, x2r, f2, e2;
  logic [AW-1:0] wa0, ra0, wa1, ra1, wa2, ra2;

  fifo_chain_slice_ctrl #(.DEPTH(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .standalone(1'b0), .load_rt(1'b1),
    .xin_pulse(x1p), .xin_rd(x1r), .xout_pulse(x0p), .xout_rd(x0r),
    .wr_valid(c_wv), .wr_ready(w0r), .rd_valid(v0), .rd_ready(c_rr),
    .mem_we(we0), .mem_waddr(wa0), .mem_re(re0), .mem_raddr(ra0),
    .full_flag(f0), .empty_flag(e0));

  fifo_chain_slice_ctrl #(.DEPTH(D)) dut_s1 (
    .clk(clk), .rst_n(rst_n), .standalone(1'b0), .load_rt(rt1),
    .xin_pulse(x0p), .xin_rd(x0r), .xout_pulse(x1p), .xout_rd(x1r),
    .wr_valid(c_wv), .wr_ready(w1r), .rd_valid(v1), .rd_ready(c_rr),
    .mem_we(we1), .mem_waddr(wa1), .mem_re(re1), .mem_raddr(ra1),
    .full_flag(f1), .empty_flag(e1));

  fifo_chain_slice_ctrl #(.DEPTH(D)) dut_s2 (
    .clk(clk), .rst_n(rst_n), .standalone(1'b1), .load_rt(rt2),
    .xin_pulse(x2ip), .xin_rd(x2ir), .xout_pulse(x2p), .xout_rd(x2r),
    .wr_valid(wv2), .wr_ready(w2r), .rd_valid(v2), .rd_ready(rr2),
    .mem_we(we2), .mem_waddr(wa2), .mem_re(re2), .mem_raddr(ra2),
    .full_flag(f2), .empty_flag(e2));

  // storage models
  logic [7:0] m0 [D];
  logic [7:0] m1 [D];
  logic [7:0] m2 [D];
  always @(posedge clk) begin
    if (we0) m0[wa0] <= c_wd;
    if (we1) m1[wa1] <= c_wd;
    if (we2) m2[wa2] <= wd2;
  end

  logic       c_wr_ready, c_rv, c_full, c_empty;
  logic [7:0] c_rdata;
  assign c_wr_ready = w0r | w1r;
  assign c_rv       = v0 | v1;
  assign c_full     = f0 | f1;
  assign c_empty    = e0 | e1;
  assign c_rdata    = v0 ? m0[ra0] : m1[ra1];

  logic [7:0] exp_q[$];
  int pops = 0, n_we1 = 0, n_xw = 0, n_xr = 0, n_x2 = 0;
  bit phase1 = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (c_rv && c_rr) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10 read with empty scoreboard", int'(c_rdata), -1);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(c_rdata == e, "R10 ring order", int'(c_rdata), int'(e));
          pops++;
        end
      end
      if (phase1 && we1) n_we1++;
      if (x0p || x1p) begin
        if ((x0p && x0r) || (x1p && x1r)) n_xr++;
        else n_xw++;
      end
      if (x2p) n_x2++;
    end
  end

  task automatic push(input logic [7:0] d);
    c_wv = 1'b1;
    c_wd = d;
    #1;
    while (!c_wr_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back(d);
    @(negedge clk);
    c_wv = 1'b0;
  endtask

  task automatic s2_push(input logic [7:0] d);
    wv2 = 1'b1;
    wd2 = d;
    #1;
    chk(w2r == 1'b1, "R6 standalone write ready", int'(w2r), 1);
    @(negedge clk);
    wv2 = 1'b0;
  endtask

  task automatic s2_pop(input logic [7:0] e, input string tag);
    rr2 = 1'b1;
    #1;
    chk(v2 == 1'b1, tag, int'(v2), 1);
    chk(m2[ra2] == e, tag, int'(m2[ra2]), int'(e));
    @(negedge clk);
    rr2 = 1'b0;
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    c_wv = 1'b0; c_rr = 1'b0; c_wd = '0; rt1 = 1'b0;
    wv2 = 1'b0; rr2 = 1'b0; rt2 = 1'b0; x2ip = 1'b0; x2ir = 1'b0; wd2 = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(w0r == 1'b1, "R1 head write ready", int'(w0r), 1);
    chk(e0 == 1'b1 && f0 == 1'b0, "R1 head flags", int'({f0, e0}), 1);
    chk(w1r == 1'b0 && v1 == 1'b0, "R1 body slice idle", int'({w1r, v1}), 0);
    chk(e1 == 1'b0 && f1 == 1'b0, "R1 body flags low", int'({f1, e1}), 0);
    chk(w2r == 1'b1 && e2 == 1'b1, "R1 standalone owns tokens", int'({w2r, e2}), 3);
    @(negedge clk);

    // fill the head slice
    phase1 = 1'b1;
    for (int i = 0; i < D; i++) push(8'h10 + 8'(i));
    #1;
    chk(x0p == 1'b1 && x0r == 1'b0, "R4 write handoff pulse", int'({x0p, x0r}), 2);
    chk(w0r == 1'b0, "R4 head released write token", int'(w0r), 0);
    chk(w1r == 1'b0, "R5 body not yet owner", int'(w1r), 0);
    @(negedge clk);
    #1;
    chk(w1r == 1'b1, "R5 body took write token", int'(w1r), 1);
    chk(x0p == 1'b0, "R4 handoff one cycle wide", int'(x0p), 0);
    chk(n_we1 == 0, "R2 no write without token", n_we1, 0);
    phase1 = 1'b0;
    @(negedge clk);

    // fill the body slice
    for (int i = 0; i < D; i++) push(8'h20 + 8'(i));
    @(negedge clk);
    #1;
    chk(c_full == 1'b1 && f0 == 1'b1, "R9 chain full from head", int'({c_full, f0}), 3);
    chk(c_wr_ready == 1'b0, "R9 full blocks writes", int'(c_wr_ready), 0);
    chk(v1 == 1'b0, "R3 data held without read token", int'(v1), 0);
    chk(v0 == 1'b1, "R3 head offers data", int'(v0), 1);
    @(negedge clk);
    // R8 the dual-purpose pin in chain mode
    rt1 = 1'b1;
    @(negedge clk);
    rt1 = 1'b0;
    #1;
    chk(c_full == 1'b1, "R8 chain retransmit ignored", int'(c_full), 1);
    @(negedge clk);

    // drain everything
    c_rr = 1'b1;
    while (pops < 2 * D) @(negedge clk);
    c_rr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    #1;
    chk(c_empty == 1'b1 && e0 == 1'b1, "R9 chain empty at head", int'({c_empty, e0}), 3);
    chk(n_xw == 2, "R4 write handoff count", n_xw, 2);
    chk(n_xr == 2, "R4 read handoff count", n_xr, 2);
    @(negedge clk);

    // concurrent traffic around the ring
    fork
      begin
        for (int i = 0; i < 20; i++) begin
          push(8'h40 + 8'(i));
          if (i % 4 == 3) @(negedge clk);
        end
      end
      begin
        for (int cyc = 0; pops < 2 * D + 20; cyc++) begin
          c_rr = (cyc % 3 != 0);
          @(negedge clk);
        end
        c_rr = 1'b0;
      end
    join
    #1;
    chk(exp_q.size() == 0, "R10 scoreboard drained", exp_q.size(), 0);
    @(negedge clk);

    // standalone slice
    s2_push(8'hA0);
    s2_push(8'hA1);
    s2_push(8'hA2);
    x2ip = 1'b1; x2ir = 1'b0;
    @(negedge clk);
    x2ir = 1'b1;
    @(negedge clk);
    x2ip = 1'b0; x2ir = 1'b0;
    #1;
    chk(w2r == 1'b1 && v2 == 1'b1, "R6 handoff input ignored", int'({w2r, v2}), 3);
    @(negedge clk);
    s2_pop(8'hA0, "R3 standalone read");
    s2_pop(8'hA1, "R3 standalone read");
    rt2 = 1'b1;
    #1;
    chk(w2r == 1'b0 && v2 == 1'b0, "R7 retransmit blocks transfers", int'({w2r, v2}), 0);
    @(negedge clk);
    rt2 = 1'b0;
    #1;
    chk(ra2 == '0, "R7 read address rewound", int'(ra2), 0);
    @(negedge clk);
    s2_pop(8'hA0, "R7 replay");
    s2_pop(8'hA1, "R7 replay");
    s2_pop(8'hA2, "R7 replay");
    #1;
    chk(v2 == 1'b0 && e2 == 1'b1, "R7 replay length", int'({v2, e2}), 1);
    @(negedge clk);
    for (int i = 0; i < D; i++) s2_push(8'hB0 + 8'(i));
    #1;
    chk(f2 == 1'b1, "R9 standalone full", int'(f2), 1);
    @(negedge clk);
    for (int i = 0; i < D; i++) s2_pop(8'hB0 + 8'(i), "R6 standalone wrap order");
    chk(n_x2 == 0, "R6 no handoff in standalone", n_x2, 0);

    finish_run();
  end

endmodule